// File: doc/BRIEF.md
# Quantized Synapse Column Programming Sequencer

This block writes pre-trained, quantized weights into a crossbar of charge-trap synapses. It does not address synapses one at a time. Instead it programs a whole column at once, using the timing-dependent plasticity of the devices. Post-synaptic neurons are visited in ascending index order. Neurons of all non-input layers are numbered consecutively, layer after layer. For each neuron, the sequencer fetches one memory word. That word holds a signed level code for every input synapse of the neuron's column.

For each nonzero level, the sequencer then runs one programming step:
- It drives a wordline enable vector that selects exactly the synapses holding that level.
- It fires a teaching pulse on the column's excitatory gate-2 line.
- The teaching pulse is shifted against the wordline pulse by a signed cycle offset. The offset comes from a per-level delay table.

Positive levels are normally given positive offsets (potentiation) and negative levels negative offsets (depression). The sequencer applies whatever the table holds.

The zero level is never driven, because an untouched synapse already represents it. The inhibitory device of each pair is never touched. A level that no synapse of the column holds is skipped without any pulse. So a column costs at most one step per nonzero level. Over the network, the worst case is (levels − 1) steps per non-input neuron. For example, 3 levels on a 784-800-10 network gives 1620 steps.

Top module: `stq_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, busy, done, the gate-2 lines and every wordline enable are low.
- R2: Within one neuron, levels are visited in the order −N, …, −1, +1, …, +N. Neurons are visited from 0 up to NUM_NEURONS−1, one weight-memory word each.
- R3: No synapse whose code is 0 is ever selected. No step is issued for the zero level.
- R4: During a step, wl_en bit i is 1 exactly when the code in weight-word bits [i*CODE_W +: CODE_W] (two's complement) equals the step's level. The mask stays constant for the whole wordline pulse.
- R5: Entry j of the delay table sits at dly_tab bits [j*DLY_W +: DLY_W], in two's complement. Entry j belongs to the j-th level of the R2 order. The rising edge of g2_exc minus the rising edge of the wordline pulse equals that entry in cycles; a negative entry puts the teaching pulse first.
- R6: The wordline pulse and the teaching pulse each stay high for exactly pulse_width cycles.
- R7: The inhibitory gate-2 line g2_inh never goes high.
- R8: A level that no synapse of the current column holds produces no pulse at all.
- R9: When every column holds every nonzero level, one run issues exactly 2·N·NUM_NEURONS steps.
- R10: done rises when the last step of the last neuron has ended, at the same time as busy falls. done stays high until the next accepted start, which clears it.
- R11: A start asserted while busy is ignored; the run in progress continues unchanged.
- R12: The word for neuron k is requested with wmem_rd_en high and wmem_addr = k, and is taken from wmem_rdata one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| pulse_width | input | PW_W | Length of each pulse in cycles (≥ 1) |
| dly_tab | input | 2·N·DLY_W | Signed teaching offsets, one per nonzero level |
| wmem_rd_en | output | 1 | Weight memory read request |
| wmem_addr | output | NW | Neuron index being read |
| wmem_rdata | input | NUM_INPUTS·CODE_W | Level codes of the column, one cycle after the request |
| wl_en | output | NUM_INPUTS | Wordline enables of the current step |
| g2_exc | output | 1 | Excitatory gate-2 teaching pulse |
| g2_inh | output | 1 | Inhibitory gate-2 line, held low |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |

## Verification
The assertions assume the following about the inputs:
- pulse_width is at least 1.
- dly_tab and pulse_width are held steady for the whole run.
- The weight memory answers with a fixed one-cycle latency.

A zero width would keep the step timer from ending, and a table change mid-run would break the pulse-offset relation. The stimulus loads the table and the width from a vector before raising start and leaves them untouched until done. The stimulus also models the memory as a registered read.

Several memory patterns are used:
- every level present in every column;
- one column missing a level;
- one column holding only zeros.

Between them, these patterns exercise the skip path as well as full columns.

// File: rtl/stq_pkg.sv
package stq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_SELECT,
        ST_PULSE
    } stq_state_e;

    typedef struct packed {
        logic wl_on;
        logic tc_on;
        logic last;
    } pulse_phase_t;

    // Level visited at order position idx: most negative first, zero skipped.
    function automatic int level_of(input int idx, input int half);
        return (idx < half) ? (idx - half) : (idx - half + 1);
    endfunction

    function automatic int code_width(input int half);
        return $clog2(half + 1) + 1;
    endfunction

endpackage

// File: rtl/stq_level_match.sv
module stq_level_match #(
    parameter int NUM_INPUTS = 8,
    parameter int CODE_W     = 3
) (
    input  logic [NUM_INPUTS*CODE_W-1:0] codes,
    input  logic signed [CODE_W-1:0]     level,
    output logic [NUM_INPUTS-1:0]        mask
);

    logic level_nz;
    assign level_nz = (level != '0);

    for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_cmp
        logic signed [CODE_W-1:0] code_i;
        assign code_i  = codes[i*CODE_W +: CODE_W];
        assign mask[i] = level_nz && (code_i == level);
    end

endmodule

// File: rtl/stq_pulse_timer.sv
module stq_pulse_timer
    import stq_pkg::*;
#(
    parameter int DLY_W = 6,
    parameter int PW_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic signed [DLY_W-1:0] delay_i,
    input  logic [PW_W-1:0]         width_i,
    output pulse_phase_t            phase_o
);

    localparam int CNT_W = DLY_W + PW_W + 1;

    logic                    run_q;
    logic [CNT_W-1:0]        t_q;
    logic signed [DLY_W-1:0] dly_q;
    logic [PW_W-1:0]         pw_q;

    logic signed [CNT_W-1:0] d_ext;
    logic [CNT_W-1:0]        mag;
    logic [CNT_W-1:0]        pw_ext;
    logic [CNT_W-1:0]        wl_start;
    logic [CNT_W-1:0]        tc_start;

    always_comb begin
        d_ext    = CNT_W'(dly_q);
        mag      = (d_ext < 0) ? CNT_W'(-d_ext) : CNT_W'(d_ext);
        pw_ext   = CNT_W'(pw_q);
        wl_start = (d_ext < 0) ? mag : '0;
        tc_start = (d_ext < 0) ? '0 : mag;
        phase_o.wl_on = run_q && (t_q >= wl_start) && (t_q < wl_start + pw_ext);
        phase_o.tc_on = run_q && (t_q >= tc_start) && (t_q < tc_start + pw_ext);
        phase_o.last  = run_q && (t_q == mag + pw_ext - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            t_q   <= '0;
            dly_q <= '0;
            pw_q  <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            t_q   <= '0;
            dly_q <= delay_i;
            pw_q  <= width_i;
        end else if (run_q) begin
            t_q <= t_q + 1'b1;
            if (phase_o.last) begin
                run_q <= 1'b0;
            end
        end
    end

    // Checker counters: length of the pulse that is high right now.
    logic [CNT_W-1:0] wl_len_q;
    logic [CNT_W-1:0] tc_len_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            wl_len_q <= '0;
            tc_len_q <= '0;
        end else begin
            wl_len_q <= phase_o.wl_on ? wl_len_q + 1'b1 : '0;
            tc_len_q <= phase_o.tc_on ? tc_len_q + 1'b1 : '0;
        end
    end

    // R6
    wl_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(phase_o.wl_on) |-> (wl_len_q == CNT_W'(pw_q)));

    // R6
    tc_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(phase_o.tc_on) |-> (tc_len_q == CNT_W'(pw_q)));

endmodule

// File: rtl/stq_seq.sv
module stq_seq
    import stq_pkg::*;
#(
    parameter int NUM_INPUTS  = 8,
    parameter int HALF_LEVELS = 2,
    parameter int NUM_NEURONS = 3,
    parameter int DLY_W       = 6,
    parameter int PW_W        = 4,
    localparam int CODE_W     = code_width(HALF_LEVELS),
    localparam int NZ_LEVELS  = 2 * HALF_LEVELS,
    localparam int NW         = (NUM_NEURONS > 1) ? $clog2(NUM_NEURONS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [PW_W-1:0]              pulse_width,
    input  logic [NZ_LEVELS*DLY_W-1:0]   dly_tab,
    output logic                         wmem_rd_en,
    output logic [NW-1:0]                wmem_addr,
    input  logic [NUM_INPUTS*CODE_W-1:0] wmem_rdata,
    output logic [NUM_INPUTS-1:0]        wl_en,
    output logic                         g2_exc,
    output logic                         g2_inh,
    output logic                         busy,
    output logic                         done
);

    localparam int LI_W = $clog2(NZ_LEVELS);
    localparam logic [LI_W-1:0] LI_LAST  = LI_W'(NZ_LEVELS - 1);
    localparam logic [NW-1:0]   NEU_LAST = NW'(NUM_NEURONS - 1);

    stq_state_e                  state_q;
    logic [NW-1:0]               neuron_q;
    logic [LI_W-1:0]             li_q;
    logic [NUM_INPUTS*CODE_W-1:0] codes_q;
    logic [NUM_INPUTS-1:0]       mask_q;
    logic                        done_q;

    logic signed [CODE_W-1:0]    cur_level;
    logic signed [DLY_W-1:0]     cur_delay;
    logic [NUM_INPUTS-1:0]       match_mask;
    logic                        timer_start;
    logic                        step_end;
    pulse_phase_t                phase;

    assign cur_level = CODE_W'(level_of(int'(li_q), HALF_LEVELS));
    assign cur_delay = dly_tab[int'(li_q)*DLY_W +: DLY_W];

    stq_level_match #(
        .NUM_INPUTS (NUM_INPUTS),
        .CODE_W     (CODE_W)
    ) u_match (
        .codes (codes_q),
        .level (cur_level),
        .mask  (match_mask)
    );

    assign timer_start = (state_q == ST_SELECT) && (match_mask != '0);

    stq_pulse_timer #(
        .DLY_W (DLY_W),
        .PW_W  (PW_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (timer_start),
        .delay_i (cur_delay),
        .width_i (pulse_width),
        .phase_o (phase)
    );

    assign step_end = ((state_q == ST_SELECT) && (match_mask == '0)) ||
                      ((state_q == ST_PULSE) && phase.last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            neuron_q <= '0;
            li_q     <= '0;
            codes_q  <= '0;
            mask_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        neuron_q <= '0;
                        done_q   <= 1'b0;
                        state_q  <= ST_FETCH;
                    end
                end
                ST_FETCH: state_q <= ST_LOAD;
                ST_LOAD: begin
                    codes_q <= wmem_rdata;
                    li_q    <= '0;
                    state_q <= ST_SELECT;
                end
                ST_SELECT, ST_PULSE: begin
                    if (timer_start) begin
                        mask_q  <= match_mask;
                        state_q <= ST_PULSE;
                    end else if (step_end) begin
                        if (li_q != LI_LAST) begin
                            li_q    <= li_q + 1'b1;
                            state_q <= ST_SELECT;
                        end else if (neuron_q != NEU_LAST) begin
                            neuron_q <= neuron_q + 1'b1;
                            state_q  <= ST_FETCH;
                        end else begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign wmem_rd_en = (state_q == ST_FETCH);
    assign wmem_addr  = neuron_q;
    assign wl_en      = phase.wl_on ? mask_q : '0;
    assign g2_exc     = phase.tc_on;
    assign g2_inh     = 1'b0;
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;

    // R10
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R8
    pulse_mask_nz_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PULSE) |-> (mask_q != '0));

    // R4
    wl_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ((wl_en != '0) && ($past(wl_en) != '0)) |-> (wl_en == $past(wl_en)));

    // R2
    level_order_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_SELECT) && ($past(state_q) != ST_LOAD))
            |-> (li_q == LI_W'($past(li_q) + 1'b1)));

    // R12
    fetch_then_load_chk: assert property (@(posedge clk) disable iff (rst)
        wmem_rd_en |=> (state_q == ST_LOAD));

    // R11
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_PULSE) && !phase.last && start) |=> (state_q == ST_PULSE));

endmodule

// File: tb/stq_seq_bench.sv
module stq_seq_bench;

    localparam int NI    = 8;
    localparam int HALF  = 2;
    localparam int NN    = 3;
    localparam int DLY_W = 6;
    localparam int PW_W  = 4;
    localparam int CW    = 3;
    localparam int NZ    = 2 * HALF;
    localparam int NW    = 2;

    typedef struct packed {
        logic [PW_W-1:0]         pw;
        logic signed [DLY_W-1:0] d3;
        logic signed [DLY_W-1:0] d2;
        logic signed [DLY_W-1:0] d1;
        logic signed [DLY_W-1:0] d0;
    } vec_t;

    localparam vec_t VECS [0:2] = '{
        '{4'd2, 6'sd4, 6'sd1,  -6'sd1, -6'sd3},
        '{4'd1, 6'sd5, 6'sd2,  -6'sd2, -6'sd5},
        '{4'd4, 6'sd2, 6'sd1,  -6'sd1, -6'sd2}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start = 1'b0;
    logic [PW_W-1:0]      pulse_width = '0;
    logic [NZ*DLY_W-1:0]  dly_tab = '0;
    logic                 wmem_rd_en;
    logic [NW-1:0]        wmem_addr;
    logic [NI*CW-1:0]     wmem_rdata;
    logic [NI-1:0]        wl_en;
    logic                 g2_exc, g2_inh, busy, done;

    int scn = 0;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    stq_seq #(
        .NUM_INPUTS (NI), .HALF_LEVELS (HALF), .NUM_NEURONS (NN),
        .DLY_W (DLY_W), .PW_W (PW_W)
    ) u_stq_seq (
        .clk (clk), .rst (rst), .start (start), .pulse_width (pulse_width),
        .dly_tab (dly_tab), .wmem_rd_en (wmem_rd_en), .wmem_addr (wmem_addr),
        .wmem_rdata (wmem_rdata), .wl_en (wl_en), .g2_exc (g2_exc),
        .g2_inh (g2_inh), .busy (busy), .done (done)
    );

    function automatic int code_of(int s, int n, int i);
        int v;
        v = ((i * 3 + n * 5 + s * 7) % 5) - 2;
        if (s == 1 && n == 1 && v == -2) v = -1;
        if (s == 2 && n == 2) v = 0;
        return v;
    endfunction

    function automatic logic [NI*CW-1:0] mem_word(int s, int n);
        logic [NI*CW-1:0] w;
        w = '0;
        for (int i = 0; i < NI; i++) w[i*CW +: CW] = CW'(code_of(s, n, i));
        return w;
    endfunction

    // Registered weight memory, one cycle latency (R12)
    always_ff @(posedge clk) begin
        if (wmem_rd_en) wmem_rdata <= mem_word(scn, int'(wmem_addr));
    end

    // Pulse monitor
    int cyc = 0;
    int wl_cnt = 0, tc_cnt = 0, inh_seen = 0;
    int wl_rise [0:31];
    int tc_rise [0:31];
    int wl_len  [0:31];
    int tc_len  [0:31];
    logic [NI-1:0] obs_mask [0:31];
    logic [NI-1:0] prev_wl = '0;
    logic prev_tc = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (g2_inh) inh_seen++;
        if (wl_en != '0 && prev_wl == '0 && wl_cnt < 32) begin
            wl_rise[wl_cnt] = cyc; obs_mask[wl_cnt] = wl_en; wl_len[wl_cnt] = 0; wl_cnt++;
        end
        if (wl_en != '0 && wl_cnt > 0) wl_len[wl_cnt-1]++;
        if (g2_exc && !prev_tc && tc_cnt < 32) begin
            tc_rise[tc_cnt] = cyc; tc_len[tc_cnt] = 0; tc_cnt++;
        end
        if (g2_exc && tc_cnt > 0) tc_len[tc_cnt-1]++;
        prev_wl = wl_en;
        prev_tc = g2_exc;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_scn(int s, bit poke_start);
        int k;
        int wait_n;
        vec_t v;
        logic signed [DLY_W-1:0] d;
        logic [NI-1:0] emask;
        v = VECS[s];
        scn = s;
        pulse_width = v.pw;
        dly_tab = {v.d3, v.d2, v.d1, v.d0};
        @(negedge clk);
        wl_cnt = 0; tc_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 start clears done", int'(done), 0);
        check("R10 busy after start", int'(busy), 1);
        if (poke_start) begin
            repeat (6) @(negedge clk);
            start = 1'b1;               // R11: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        wait_n = 0;
        while (!done && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        check("R10 busy low with done", int'(busy), 0);
        k = 0;
        for (int n = 0; n < NN; n++) begin
            for (int li = 0; li < NZ; li++) begin
                int lvl;
                lvl = (li < HALF) ? li - HALF : li - HALF + 1;
                emask = '0;
                for (int i = 0; i < NI; i++) if (code_of(s, n, i) == lvl) emask[i] = 1'b1;
                case (li)
                    0: d = v.d0;
                    1: d = v.d1;
                    2: d = v.d2;
                    default: d = v.d3;
                endcase
                if (emask != '0 && k < wl_cnt && k < tc_cnt) begin
                    check("R2 R3 R4 R12 wordline mask", int'(obs_mask[k]), int'(emask));
                    check("R5 teaching offset", tc_rise[k] - wl_rise[k], int'(d));
                    check("R6 wordline width", wl_len[k], int'(v.pw));
                    check("R6 teaching width", tc_len[k], int'(v.pw));
                end
                if (emask != '0) k++;
            end
        end
        check("R8 R11 wordline pulse count", wl_cnt, k);
        check("R8 teaching pulse count", tc_cnt, k);
        if (s == 0) check("R9 full step count", k, NZ * NN);
        repeat (3) @(negedge clk);
        check("R10 done held", int'(done), 1);
        check("R7 inhibitory line low", inh_seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 done in reset", int'(done), 0);
        check("R1 wordlines in reset", int'(wl_en), 0);
        check("R1 gate2 in reset", int'(g2_exc), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 done after reset", int'(done), 0);
        run_scn(0, 1'b0);
        run_scn(1, 1'b1);
        run_scn(2, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule